// File: doc/BRIEF.md
# Cross-Path Issue Checker for a Two-Sided Datapath

This block inspects one execute packet of parallel instructions for a machine whose registers are split across two sides, A and B. Each side has a single cross-path, and a functional unit on that side reads an operand from the other side's register file through it. At most one instruction per side may use that path in a cycle. So a packet may contain two cross-path instructions only when one is on side A and the other is on side B.

Each packet slot carries three bits: valid, side and cross-path. The checker counts the cross-path users on each side. It raises a combinational legal flag and a per-slot mask that marks every instruction involved in a conflict. A parameter selects an optional registered copy of the legal flag for timing-critical consumers. Instruction decoding and execution belong to other blocks.

Top module: `xpath_checker`

## Requirements
- R1: A slot counts toward its side's cross-path usage only when its valid bit and its cross-path bit are both 1. A slot with valid 0 has no effect on any output, whatever its other bits hold.
- R2: `packetLegal` is 1 when neither side has more than one counted slot.
- R3: `packetLegal` is 0 when either side has two or more counted slots.
- R4: A packet whose counted slots are exactly one on side A (side bit 0) and one on side B (side bit 1) is legal.
- R5: Bit i of `conflictMask` is 1 exactly when slot i is counted and its side has two or more counted slots. Otherwise the bit is 0.
- R6: A packet with no counted slots gives `packetLegal` = 1 and `conflictMask` = 0.
- R7: With `REG_OUT` = 1, `packetLegalQ` equals the `packetLegal` value present at the previous rising clock edge. It is 1 while `rstN` is low.
- R8: `conflictMask` never flags a slot that is not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the registered legal copy |
| rstN | input | 1 | Active-low synchronous reset |
| slotValid | input | NUM_SLOTS | Per-slot instruction present |
| slotSide | input | NUM_SLOTS | Per-slot side, 0 = A, 1 = B |
| slotXpath | input | NUM_SLOTS | Per-slot cross-path use flag |
| packetLegal | output | 1 | Combinational packet legality |
| conflictMask | output | NUM_SLOTS | Slots involved in a cross-path conflict |
| packetLegalQ | output | 1 | Registered copy of packetLegal |

## Verification
The assertions assume that the packet inputs are known (not X) and steady during each clock cycle. They also assume that the registered copy is only meaningful once a reset has been applied. The bench drives each packet just after a rising edge and checks it at the falling edge. It holds the inputs at zero during reset. The stimulus includes directed packets for empty, split-side, same-side, invalid-slot and fully loaded cases. It then adds pseudo-random packets, each compared against a behavioural count model in the bench.

// File: rtl/xpath_pkg.sv
package xpath_pkg;
  localparam logic SIDE_A = 1'b0;
  localparam logic SIDE_B = 1'b1;

  typedef struct packed {
    logic overA;
    logic overB;
  } xpathStrobe_t;
endpackage

// File: rtl/xpath_datapath.sv
module xpath_datapath
  import xpath_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter bit REG_OUT   = 1'b1,
  localparam int CNT_W    = $clog2(NUM_SLOTS + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_SLOTS-1:0] slotValid,
  input  logic [NUM_SLOTS-1:0] slotSide,
  input  logic [NUM_SLOTS-1:0] slotXpath,
  input  xpathStrobe_t         strobe,
  input  logic                 legalIn,
  output logic [CNT_W-1:0]     countA,
  output logic [CNT_W-1:0]     countB,
  output logic [NUM_SLOTS-1:0] conflictMask,
  output logic                 packetLegalQ
);
  logic [NUM_SLOTS-1:0] usedSlot;

  assign usedSlot = slotValid & slotXpath;

  always_comb begin
    countA = '0;
    countB = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (usedSlot[i] && slotSide[i] == SIDE_A) countA = countA + CNT_W'(1);
      if (usedSlot[i] && slotSide[i] == SIDE_B) countB = countB + CNT_W'(1);
    end
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : gMask
    assign conflictMask[g] = usedSlot[g] &
                             ((slotSide[g] == SIDE_B) ? strobe.overB : strobe.overA);
  end

  if (REG_OUT) begin : gReg
    logic legalReg;
    always_ff @(posedge clk) begin
      if (!rstN) legalReg <= 1'b1;
      else       legalReg <= legalIn;
    end
    assign packetLegalQ = legalReg;

    p_reg_copy_r7: assert property (@(posedge clk) disable iff (!rstN)
      $past(rstN) |-> packetLegalQ == $past(legalIn));
  end else begin : gComb
    assign packetLegalQ = legalIn;
  end

  p_mask_counted_r8: assert property (@(posedge clk) disable iff (!rstN)
    (conflictMask & ~(slotValid & slotXpath)) == '0);
  p_mask_illegal_r5: assert property (@(posedge clk) disable iff (!rstN)
    (|conflictMask) |-> !legalIn);
  p_mask_pair_r3: assert property (@(posedge clk) disable iff (!rstN)
    !legalIn |-> $countones(conflictMask) >= 2);
endmodule

// File: rtl/xpath_control.sv
module xpath_control
  import xpath_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  localparam int CNT_W    = $clog2(NUM_SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] countA,
  input  logic [CNT_W-1:0] countB,
  output xpathStrobe_t     strobe,
  output logic             packetLegal
);
  always_comb begin
    strobe.overA = countA > CNT_W'(1);
    strobe.overB = countB > CNT_W'(1);
    packetLegal  = !(strobe.overA || strobe.overB);
  end

  p_split_legal_r4: assert property (@(posedge clk) disable iff (!rstN)
    (countA <= CNT_W'(1) && countB <= CNT_W'(1)) |-> packetLegal);
  p_none_legal_r6: assert property (@(posedge clk) disable iff (!rstN)
    (countA == '0 && countB == '0) |-> packetLegal);
endmodule

// File: rtl/xpath_checker.sv
module xpath_checker
  import xpath_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter bit REG_OUT   = 1'b1,
  localparam int CNT_W    = $clog2(NUM_SLOTS + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_SLOTS-1:0] slotValid,
  input  logic [NUM_SLOTS-1:0] slotSide,
  input  logic [NUM_SLOTS-1:0] slotXpath,
  output logic                 packetLegal,
  output logic [NUM_SLOTS-1:0] conflictMask,
  output logic                 packetLegalQ
);
  xpathStrobe_t     strobe;
  logic [CNT_W-1:0] countA;
  logic [CNT_W-1:0] countB;

  xpath_datapath #(.NUM_SLOTS(NUM_SLOTS), .REG_OUT(REG_OUT)) u_datapath (
    .clk(clk), .rstN(rstN),
    .slotValid(slotValid), .slotSide(slotSide), .slotXpath(slotXpath),
    .strobe(strobe), .legalIn(packetLegal),
    .countA(countA), .countB(countB),
    .conflictMask(conflictMask), .packetLegalQ(packetLegalQ)
  );

  xpath_control #(.NUM_SLOTS(NUM_SLOTS)) u_control (
    .clk(clk), .rstN(rstN),
    .countA(countA), .countB(countB),
    .strobe(strobe), .packetLegal(packetLegal)
  );
endmodule

// File: tb/xpath_checker_bench.sv
module xpath_checker_bench;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [N-1:0] slotValid = '0;
  logic [N-1:0] slotSide = '0;
  logic [N-1:0] slotXpath = '0;
  logic         packetLegal;
  logic [N-1:0] conflictMask;
  logic         packetLegalQ;

  int testCount = 0;
  int failCount = 0;
  logic prevLegal = 1'b1;

  always #2 clk = ~clk;

  xpath_checker #(.NUM_SLOTS(N), .REG_OUT(1'b1)) u_xpath_checker (
    .clk(clk), .rstN(rstN),
    .slotValid(slotValid), .slotSide(slotSide), .slotXpath(slotXpath),
    .packetLegal(packetLegal), .conflictMask(conflictMask),
    .packetLegalQ(packetLegalQ)
  );

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic applyPacket(input logic [N-1:0] v, input logic [N-1:0] s,
                             input logic [N-1:0] x, input string tag);
    int usedA;
    int usedB;
    logic expLegal;
    logic [N-1:0] expMask;
    @(posedge clk);
    #1;
    slotValid = v; slotSide = s; slotXpath = x;
    @(negedge clk);
    usedA = 0; usedB = 0;
    for (int i = 0; i < N; i++) begin
      if (v[i] && x[i]) begin
        if (s[i]) usedB++; else usedA++;
      end
    end
    expLegal = (usedA < 2) && (usedB < 2);
    expMask = '0;
    for (int i = 0; i < N; i++) begin
      if (v[i] && x[i] && ((s[i] && usedB > 1) || (!s[i] && usedA > 1))) expMask[i] = 1'b1;
    end
    check({tag, " legal"}, N'(packetLegal), N'(expLegal));
    check("R5 mask", conflictMask, expMask);
    check("R8 mask within counted", conflictMask & ~(v & x), '0);
    check("R7 registered copy", N'(packetLegalQ), N'(prevLegal));
    prevLegal = expLegal;
  endtask

  initial begin
    #(4 * 200000);
    failCount++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R7 reset value", N'(packetLegalQ), N'(1'b1));
    rstN = 1'b1;
    applyPacket(8'hFF, 8'h00, 8'h00, "R6 no cross-path");
    applyPacket(8'h03, 8'h02, 8'h03, "R4 one per side");
    applyPacket(8'h03, 8'h00, 8'h03, "R3 two on A");
    applyPacket(8'h30, 8'h30, 8'h30, "R3 two on B");
    applyPacket(8'h01, 8'h00, 8'hFF, "R1 invalid xpath ignored");
    applyPacket(8'h00, 8'hFF, 8'hFF, "R6 empty packet");
    applyPacket(8'hFF, 8'hF0, 8'hFF, "R3 full packet");
    applyPacket(8'h81, 8'h80, 8'h81, "R2 single each side");
    applyPacket(8'h05, 8'h00, 8'h05, "R3 back to illegal");
    applyPacket(8'h10, 8'h00, 8'h10, "R2 one on A");
    for (int k = 0; k < 300; k++) begin
      applyPacket(N'($urandom), N'($urandom), N'($urandom) & N'($urandom), "R2 R3 random");
    end
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule